// File: doc/BRIEF.md
# Streaming 3x3 Cellular Network Iteration Core

This block advances every cell of a raster image by one discrete time step of a space-invariant cellular nonlinear network. Cell states arrive one per three clock cycles in raster order, each paired with a precomputed per-cell constant that already holds the input-template contribution and the bias. The block returns the updated states in the same raster order, each with its own constant passed through unchanged. A start pulse marks the first output of every frame. Because the output stream keeps the same three-cycle spacing and pairing as the input stream, the outputs of one core can feed the next one directly, with one core per iteration.

The nine feedback coefficients are loaded through a small write port while no frame is in flight. The time step is already folded into these coefficients, and the centre coefficient also carries the decay term. The update is therefore a plain sum: the old state, plus the weighted 3x3 neighbourhood, plus the cell constant. Inside the block, two line delays and a three-column window present the neighbourhood. Three multipliers work through the window one column per cycle. Cells outside the image take the value of the nearest real cell.

Top module: `cnn_iter_core`

## Requirements
- R1: While reset is high and after its release, `out_valid`, `start_out`, `state_out` and `const_out` read zero until a frame produces its first result.
- R2: For the cell at row r, column c, the result is T = sum over k of K[k]*S(neighbour k) + 64*S(r,c) + 64*G(r,c), all in integers. Here K[k] is the coefficient written with `coef_sel` = k, row-major over the window (0 = up-left, 4 = centre, 8 = down-right), and states, constants and coefficients are two's-complement values with 6 fractional bits.
- R3: A neighbour outside the image takes the value of the nearest in-image cell: row index clamped to [0, IMG_H-1] and column index clamped to [0, IMG_W-1].
- R4: The output state is T/64 rounded toward zero, then clamped to the range [-64, +63] raw (that is, [-1, +63/64]).
- R5: Input pixel n of a frame is presented with `in_valid` exactly 3n cycles after the `start_in` cycle. The block emits exactly IMG_W*IMG_H results in raster order, with `out_valid` high for one cycle every third cycle. The first result is visible 3*(IMG_W+2)+1 cycles after the clock edge that samples `start_in`.
- R6: `start_out` is high together with the first result of a frame, and only with that result.
- R7: `const_out` carries, unchanged, the constant that arrived with the same cell as the result.
- R8: A coefficient write while a frame is in progress has no effect, and a write with `coef_sel` above 8 has no effect. An idle write to selector 0..8 is used by every later frame.
- R9: A new frame may start in the cycle right after the last result of the previous frame, and it is computed without influence from the earlier frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_in | input | 1 | Marks pixel 0 of a frame; accepted only while idle |
| in_valid | input | 1 | Qualifies `state_in` / `const_in` |
| state_in | input | STATE_W | Previous cell state, signed fixed point |
| const_in | input | CONST_W | Per-cell constant, signed fixed point |
| coef_we | input | 1 | Coefficient write strobe |
| coef_sel | input | 4 | Coefficient selector, 0..8 row-major |
| coef_val | input | COEF_W | Coefficient value, signed fixed point |
| start_out | output | 1 | First result of a frame |
| out_valid | output | 1 | Qualifies `state_out` / `const_out` |
| state_out | output | STATE_W | Updated cell state |
| const_out | output | CONST_W | Cell constant passed through |

## Verification
The assertions rely on two promises about the inputs. `in_valid` only rises on the slot-boundary cycle of the three-cycle grid fixed by `start_in`, and `start_in` never arrives while a frame is in flight. The bench keeps to both. Every pixel is driven on a strict three-cycle grid counted from the start pulse, and the next frame is launched only after the final result of the previous one has been seen. The one write attempted during a frame is timed to land mid-stream, so it exercises the ignore rule without breaking the grid.

// File: rtl/cnn_pkg.sv
package cnn_pkg;

  // Window geometry shared by all pieces of the core.
  localparam int KDIM = 3;
  localparam int TAPS = KDIM * KDIM;

  // Phase inside a three-cycle slot. PH_ADV is the cycle that takes a
  // new pixel, shifts the window and finishes the previous result.
  typedef enum logic [1:0] {
    PH_ADV    = 2'd0,
    PH_LEFT   = 2'd1,
    PH_CENTER = 2'd2
  } phase_e;

  // Window column handled in a given phase.
  function automatic int phase_col(phase_e ph);
    case (ph)
      PH_LEFT:   return 0;
      PH_CENTER: return 1;
      default:   return 2;
    endcase
  endfunction

endpackage

// File: rtl/cnn_line_delay.sv
// Ring-buffer delay of DEPTH advances, written so that block RAM can be
// inferred: one read-before-write access per advance.
module cnn_line_delay #(
  parameter int DW    = 8,
  parameter int DEPTH = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] ptr;

  always_ff @(posedge clk) begin
    if (adv) begin
      dout     <= mem[ptr];
      mem[ptr] <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (adv) begin
      ptr <= (ptr == PTR_LAST) ? '0 : PW'(ptr + 1'b1);
    end
  end

endmodule

// File: rtl/cnn_ctrl.sv
// Slot sequencer: three-cycle phase, slot count over the frame plus the
// flush slots, output position and border flags of the current window.
module cnn_ctrl import cnn_pkg::*; #(
  parameter int IMG_W = 64,
  parameter int IMG_H = 48
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   start_in,
  output logic   running,
  output phase_e phase,
  output logic   adv,
  output logic   feed,
  output logic   win_vld,
  output logic   win_first,
  output logic   edge_top,
  output logic   edge_bot,
  output logic   edge_lft,
  output logic   edge_rgt
);
  localparam int NPIX      = IMG_W * IMG_H;
  localparam int FIRST_OUT = IMG_W + 1;
  localparam int LAST_WIN  = (IMG_H + 1) * IMG_W;
  localparam int LAST_SLOT = LAST_WIN + 1;
  localparam int SLOT_W    = $clog2(LAST_SLOT + 1);
  localparam int ROW_W     = $clog2(IMG_H + 1);
  localparam int COL_W     = $clog2(IMG_W + 1);

  logic [SLOT_W-1:0] slot;
  logic [SLOT_W-1:0] cur_slot;
  logic [ROW_W-1:0]  orow;
  logic [COL_W-1:0]  ocol;
  logic              emit;

  always_comb begin
    adv      = running ? (phase == PH_ADV) : start_in;
    cur_slot = running ? slot : '0;
    feed     = adv && (cur_slot < SLOT_W'(NPIX));
    emit     = (cur_slot >= SLOT_W'(FIRST_OUT)) && (cur_slot <= SLOT_W'(LAST_WIN));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running   <= 1'b0;
      phase     <= PH_ADV;
      slot      <= '0;
      orow      <= '0;
      ocol      <= '0;
      win_vld   <= 1'b0;
      win_first <= 1'b0;
      edge_top  <= 1'b0;
      edge_bot  <= 1'b0;
      edge_lft  <= 1'b0;
      edge_rgt  <= 1'b0;
    end else begin
      if (!running) begin
        if (start_in) begin
          running <= 1'b1;
          phase   <= PH_LEFT;
          slot    <= SLOT_W'(1);
          orow    <= '0;
          ocol    <= '0;
        end
      end else begin
        unique case (phase)
          PH_LEFT:   phase <= PH_CENTER;
          PH_CENTER: phase <= PH_ADV;
          default: begin
            phase <= PH_LEFT;
            slot  <= slot + 1'b1;
            if (slot == SLOT_W'(LAST_SLOT)) begin
              running <= 1'b0;
              phase   <= PH_ADV;
            end
          end
        endcase
      end

      if (adv) begin
        win_vld <= emit;
        if (emit) begin
          win_first <= (orow == '0) && (ocol == '0);
          edge_top  <= (orow == '0);
          edge_bot  <= (orow == ROW_W'(IMG_H - 1));
          edge_lft  <= (ocol == '0);
          edge_rgt  <= (ocol == COL_W'(IMG_W - 1));
          if (ocol == COL_W'(IMG_W - 1)) begin
            ocol <= '0;
            orow <= orow + 1'b1;
          end else begin
            ocol <= ocol + 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/cnn_window.sv
// Three-column window. Column 2 is the newest vertical triplet (bottom
// from a register, middle and top from the line delays); columns 1 and 0
// are older copies. Border flags replace out-of-image cells with the
// nearest real one, then the column for the current phase is presented.
module cnn_window import cnn_pkg::*; #(
  parameter int SW = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 adv,
  input  phase_e               phase,
  input  logic signed [SW-1:0] pix,
  input  logic signed [SW-1:0] mid_in,
  input  logic signed [SW-1:0] top_in,
  input  logic                 edge_top,
  input  logic                 edge_bot,
  input  logic                 edge_lft,
  input  logic                 edge_rgt,
  output logic signed [SW-1:0] tap_top,
  output logic signed [SW-1:0] tap_mid,
  output logic signed [SW-1:0] tap_bot,
  output logic signed [SW-1:0] ctr
);
  logic signed [SW-1:0] new_bot;
  logic signed [SW-1:0] c1_t, c1_m, c1_b;
  logic signed [SW-1:0] c0_t, c0_m, c0_b;
  logic signed [SW-1:0] sel_t, sel_m, sel_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      new_bot <= '0;
      c1_t <= '0; c1_m <= '0; c1_b <= '0;
      c0_t <= '0; c0_m <= '0; c0_b <= '0;
    end else if (adv) begin
      new_bot <= pix;
      c1_t <= top_in;  c1_m <= mid_in;  c1_b <= new_bot;
      c0_t <= c1_t;    c0_m <= c1_m;    c0_b <= c1_b;
    end
  end

  always_comb begin
    sel_t = c1_t;
    sel_m = c1_m;
    sel_b = c1_b;
    unique case (phase)
      PH_LEFT: begin
        if (!edge_lft) begin
          sel_t = c0_t; sel_m = c0_m; sel_b = c0_b;
        end
      end
      PH_ADV: begin
        if (!edge_rgt) begin
          sel_t = top_in; sel_m = mid_in; sel_b = new_bot;
        end
      end
      default: ;
    endcase
    tap_mid = sel_m;
    tap_top = edge_top ? sel_m : sel_t;
    tap_bot = edge_bot ? sel_m : sel_b;
    ctr     = c1_m;
  end

endmodule

// File: rtl/cnn_mac.sv
// Three multipliers shared over three cycles: left column, centre column
// plus the old state, right column plus the cell constant, then rounding
// toward zero and clamping into the output register.
module cnn_mac import cnn_pkg::*; #(
  parameter int SW    = 8,
  parameter int FRAC  = 6,
  parameter int CW    = 10,
  parameter int KW    = 8,
  parameter int ACC_W = 21
) (
  input  logic                 clk,
  input  logic                 rst,
  input  phase_e               phase,
  input  logic                 adv,
  input  logic                 win_vld,
  input  logic                 win_first,
  input  logic signed [SW-1:0] v_top,
  input  logic signed [SW-1:0] v_mid,
  input  logic signed [SW-1:0] v_bot,
  input  logic signed [SW-1:0] ctr,
  input  logic signed [CW-1:0] g,
  input  logic signed [KW-1:0] k_top,
  input  logic signed [KW-1:0] k_mid,
  input  logic signed [KW-1:0] k_bot,
  output logic signed [SW-1:0] state_q,
  output logic signed [CW-1:0] const_q,
  output logic                 vld_q,
  output logic                 first_q
);
  localparam int PW = SW + KW;
  localparam int MAXV = (1 << FRAC) - 1;
  localparam int MINV = -(1 << FRAC);
  localparam logic signed [ACC_W-1:0] HI_L = ACC_W'(MAXV);
  localparam logic signed [ACC_W-1:0] LO_L = ACC_W'(MINV);

  logic signed [SW-1:0]    vals [KDIM];
  logic signed [KW-1:0]    ks   [KDIM];
  logic signed [PW-1:0]    prod [KDIM];
  logic signed [ACC_W-1:0] psum, acc, total, mag, q, sat;

  assign vals[0] = v_top;
  assign vals[1] = v_mid;
  assign vals[2] = v_bot;
  assign ks[0]   = k_top;
  assign ks[1]   = k_mid;
  assign ks[2]   = k_bot;

  generate
    for (genvar i = 0; i < KDIM; i++) begin : g_mul
      assign prod[i] = vals[i] * ks[i];
    end
  endgenerate

  always_comb begin
    psum  = ACC_W'(prod[0]) + ACC_W'(prod[1]) + ACC_W'(prod[2]);
    total = acc + psum + (ACC_W'(g) <<< FRAC);
    mag   = total[ACC_W-1] ? -total : total;
    mag   = mag >>> FRAC;
    q     = total[ACC_W-1] ? -mag : mag;
    if (q > HI_L)      sat = HI_L;
    else if (q < LO_L) sat = LO_L;
    else               sat = q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= '0;
      state_q <= '0;
      const_q <= '0;
      vld_q   <= 1'b0;
      first_q <= 1'b0;
    end else begin
      vld_q   <= adv && win_vld;
      first_q <= adv && win_vld && win_first;
      unique case (phase)
        PH_LEFT:   acc <= psum;
        PH_CENTER: acc <= acc + psum + (ACC_W'(ctr) <<< FRAC);
        default: ;
      endcase
      if (adv && win_vld) begin
        state_q <= sat[SW-1:0];
        const_q <= g;
      end
    end
  end

endmodule

// File: rtl/cnn_iter_core.sv
module cnn_iter_core import cnn_pkg::*; #(
  parameter int IMG_W   = 64,
  parameter int IMG_H   = 48,
  parameter int STATE_W = 8,
  parameter int FRAC_W  = 6,
  parameter int CONST_W = 10,
  parameter int COEF_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start_in,
  input  logic                      in_valid,
  input  logic signed [STATE_W-1:0] state_in,
  input  logic signed [CONST_W-1:0] const_in,
  input  logic                      coef_we,
  input  logic [3:0]                coef_sel,
  input  logic signed [COEF_W-1:0]  coef_val,
  output logic                      start_out,
  output logic                      out_valid,
  output logic signed [STATE_W-1:0] state_out,
  output logic signed [CONST_W-1:0] const_out
);
  localparam int PROD_W = STATE_W + COEF_W;
  localparam int SH_W   = CONST_W + FRAC_W;
  localparam int ACC_W  = ((PROD_W > SH_W) ? PROD_W : SH_W) + 5;
  localparam int FLAT_W = TAPS * COEF_W;

  // Coefficient bank, row-major over the window.
  logic signed [COEF_W-1:0] coef_r [TAPS];
  logic [FLAT_W-1:0]        coef_flat;
  logic signed [COEF_W-1:0] k_top, k_mid, k_bot;

  logic   running, adv, feed, win_vld, win_first;
  logic   edge_top, edge_bot, edge_lft, edge_rgt;
  phase_e phase;

  logic signed [STATE_W-1:0] pix, lb0_q, lb1_q;
  logic signed [CONST_W-1:0] gin, g_q;
  logic signed [STATE_W-1:0] tap_top, tap_mid, tap_bot, ctr;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < TAPS; i++) coef_r[i] <= '0;
    end else if (coef_we && !running && (coef_sel < 4'(TAPS))) begin
      coef_r[coef_sel] <= coef_val;
    end
  end

  generate
    for (genvar i = 0; i < TAPS; i++) begin : g_flat
      assign coef_flat[i*COEF_W +: COEF_W] = coef_r[i];
    end
  endgenerate

  always_comb begin
    int col;
    col   = phase_col(phase);
    k_top = coef_r[col];
    k_mid = coef_r[KDIM + col];
    k_bot = coef_r[2*KDIM + col];
  end

  // Flush slots after the frame feed zeros; their values are never used.
  assign pix = (feed && in_valid) ? state_in : '0;
  assign gin = (feed && in_valid) ? const_in : '0;

  cnn_ctrl #(.IMG_W(IMG_W), .IMG_H(IMG_H)) ctrl_i (
    .clk(clk), .rst(rst), .start_in(start_in),
    .running(running), .phase(phase), .adv(adv), .feed(feed),
    .win_vld(win_vld), .win_first(win_first),
    .edge_top(edge_top), .edge_bot(edge_bot),
    .edge_lft(edge_lft), .edge_rgt(edge_rgt)
  );

  // Line delays: one row for the middle tap, one row less one for the top
  // tap (its input is already one advance late), one row plus one for the
  // constant so it lines up with the centre of the window.
  cnn_line_delay #(.DW(STATE_W), .DEPTH(IMG_W)) lb_mid_i (
    .clk(clk), .rst(rst), .adv(adv), .din(pix), .dout(lb0_q)
  );
  cnn_line_delay #(.DW(STATE_W), .DEPTH(IMG_W - 1)) lb_top_i (
    .clk(clk), .rst(rst), .adv(adv), .din(lb0_q), .dout(lb1_q)
  );
  cnn_line_delay #(.DW(CONST_W), .DEPTH(IMG_W + 1)) lb_const_i (
    .clk(clk), .rst(rst), .adv(adv), .din(gin), .dout(g_q)
  );

  cnn_window #(.SW(STATE_W)) win_i (
    .clk(clk), .rst(rst), .adv(adv), .phase(phase),
    .pix(pix), .mid_in(lb0_q), .top_in(lb1_q),
    .edge_top(edge_top), .edge_bot(edge_bot),
    .edge_lft(edge_lft), .edge_rgt(edge_rgt),
    .tap_top(tap_top), .tap_mid(tap_mid), .tap_bot(tap_bot), .ctr(ctr)
  );

  cnn_mac #(
    .SW(STATE_W), .FRAC(FRAC_W), .CW(CONST_W), .KW(COEF_W), .ACC_W(ACC_W)
  ) mac_i (
    .clk(clk), .rst(rst), .phase(phase), .adv(adv),
    .win_vld(win_vld), .win_first(win_first),
    .v_top(tap_top), .v_mid(tap_mid), .v_bot(tap_bot), .ctr(ctr), .g(g_q),
    .k_top(k_top), .k_mid(k_mid), .k_bot(k_bot),
    .state_q(state_out), .const_q(const_out),
    .vld_q(out_valid), .first_q(start_out)
  );

endmodule

// File: rtl/cnn_iter_core_chk.sv
module cnn_iter_core_chk import cnn_pkg::*; #(
  parameter int STATE_W = 8,
  parameter int FRAC_W  = 6,
  parameter int FLAT_W  = 72
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      start_in,
  input logic                      in_valid,
  input logic                      running,
  input phase_e                    phase,
  input logic                      out_valid,
  input logic                      start_out,
  input logic signed [STATE_W-1:0] state_out,
  input logic [FLAT_W-1:0]         coef_flat
);
  localparam int HI = (1 << FRAC_W) - 1;
  localparam int LO = -(1 << FRAC_W);

  AST_OUT_RANGE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (int'(state_out) <= HI) && (int'(state_out) >= LO)); // R4
  AST_OUT_GAP1: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid); // R5
  AST_OUT_GAP2: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> ##1 !out_valid); // R5
  AST_IN_ON_GRID: assert property (@(posedge clk) disable iff (rst)
    (in_valid && running) |-> (phase == PH_ADV)); // R5
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    running |-> !start_in); // R9
  AST_START_WITH_DATA: assert property (@(posedge clk) disable iff (rst)
    start_out |-> out_valid); // R6
  AST_COEF_FROZEN: assert property (@(posedge clk) disable iff (rst)
    running |=> $stable(coef_flat)); // R8

endmodule

bind cnn_iter_core cnn_iter_core_chk #(
  .STATE_W(STATE_W), .FRAC_W(FRAC_W), .FLAT_W(FLAT_W)
) chk_i (
  .clk(clk), .rst(rst), .start_in(start_in), .in_valid(in_valid),
  .running(running), .phase(phase), .out_valid(out_valid),
  .start_out(start_out), .state_out(state_out), .coef_flat(coef_flat)
);

// File: tb/cnn_iter_core_tb_top.sv
`timescale 1ns/1ps
module cnn_iter_core_tb_top;
  localparam int TW  = 10;
  localparam int TH  = 5;
  localparam int NPX = TW * TH;
  localparam int SW  = 8;
  localparam int FR  = 6;
  localparam int CW  = 10;
  localparam int KW  = 8;
  localparam int LAT = 3 * (TW + 2) + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_in = 1'b0, in_valid = 1'b0, coef_we = 1'b0;
  logic signed [SW-1:0] state_in = '0;
  logic signed [CW-1:0] const_in = '0;
  logic [3:0]           coef_sel = '0;
  logic signed [KW-1:0] coef_val = '0;
  logic start_out, out_valid;
  logic signed [SW-1:0] state_out;
  logic signed [CW-1:0] const_out;

  always #2.5 clk = ~clk;

  cnn_iter_core #(
    .IMG_W(TW), .IMG_H(TH), .STATE_W(SW), .FRAC_W(FR), .CONST_W(CW), .COEF_W(KW)
  ) dut_i (
    .clk(clk), .rst(rst), .start_in(start_in), .in_valid(in_valid),
    .state_in(state_in), .const_in(const_in), .coef_we(coef_we),
    .coef_sel(coef_sel), .coef_val(coef_val), .start_out(start_out),
    .out_valid(out_valid), .state_out(state_out), .const_out(const_out)
  );

  int n_chk = 0, n_bad = 0;
  int pc = 0, pc_start = 0, out_idx = 0;
  int fr_state [NPX];
  int fr_const [NPX];
  int exp_st   [NPX];
  int mdl_coef [9];

  always @(posedge clk) pc <= pc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int clampi(int v, int lo, int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  // Behavioural model of one cell update.
  function automatic int model_cell(int r, int c);
    int acc = 0;
    for (int dr = -1; dr <= 1; dr++) begin
      for (int dc = -1; dc <= 1; dc++) begin
        int rr = clampi(r + dr, 0, TH - 1);
        int cc = clampi(c + dc, 0, TW - 1);
        acc += mdl_coef[(dr + 1) * 3 + (dc + 1)] * fr_state[rr * TW + cc];
      end
    end
    acc += (1 << FR) * fr_state[r * TW + c] + (1 << FR) * fr_const[r * TW + c];
    acc = acc / (1 << FR);
    return clampi(acc, -(1 << FR), (1 << FR) - 1);
  endfunction

  // Output monitor, sampling away from the active edge.
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (out_idx < NPX) begin
        chk(int'(state_out) == exp_st[out_idx], "R2 state", int'(state_out), exp_st[out_idx]);
        chk(int'(const_out) == fr_const[out_idx], "R7 const", int'(const_out), fr_const[out_idx]);
        chk(start_out == (out_idx == 0), "R6 start_out", int'(start_out), int'(out_idx == 0));
        if (out_idx == 0)
          chk((pc - pc_start) == LAT, "R5 latency", pc - pc_start, LAT);
      end else begin
        chk(1'b0, "R5 extra output", out_idx + 1, NPX);
      end
      out_idx++;
    end
  end

  task automatic write_coef(input int idx, input int val);
    @(negedge clk);
    coef_we = 1'b1; coef_sel = 4'(idx); coef_val = KW'(val);
    @(negedge clk);
    coef_we = 1'b0;
    if (idx < 9) mdl_coef[idx] = val;
  endtask

  task automatic set_all_coefs(input int v [9]);
    for (int i = 0; i < 9; i++) write_coef(i, v[i]);
  endtask

  // Drives one frame on the three-cycle grid and waits for all results.
  task automatic run_frame(input bit bad_write);
    int guard;
    for (int r = 0; r < TH; r++)
      for (int c = 0; c < TW; c++) exp_st[r * TW + c] = model_cell(r, c);
    out_idx = 0;
    pc_start = pc;
    for (int n = 0; n < NPX; n++) begin
      start_in = (n == 0);
      in_valid = 1'b1;
      state_in = SW'(fr_state[n]);
      const_in = CW'(fr_const[n]);
      if (bad_write && n == NPX / 2) begin
        coef_we = 1'b1; coef_sel = 4'd4; coef_val = KW'(99);  // R8: ignored
      end
      @(negedge clk);
      start_in = 1'b0; in_valid = 1'b0; coef_we = 1'b0;
      @(negedge clk);
      @(negedge clk);
    end
    guard = 0;
    while (out_idx < NPX && guard < 4 * LAT) begin
      @(negedge clk); #1;
      guard++;
    end
    chk(out_idx == NPX, "R5 result count", out_idx, NPX);
  endtask

  task automatic fill_random(input int lo, input int hi, input int glo, input int ghi);
    for (int n = 0; n < NPX; n++) begin
      fr_state[n] = lo + int'($urandom_range(hi - lo));
      fr_const[n] = glo + int'($urandom_range(ghi - glo));
    end
  endtask

  initial begin
    int seedv;
    int cz [9];
    seedv = $urandom(32'h1c2b);
    for (int i = 0; i < 9; i++) begin mdl_coef[i] = 0; cz[i] = 0; end
    repeat (5) @(negedge clk);
    chk(out_valid == 1'b0 && start_out == 1'b0, "R1 flags in reset", int'(out_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0 && start_out == 1'b0, "R1 flags after reset", int'(start_out), 0);
    chk(state_out == '0 && const_out == '0, "R1 data after reset", int'(state_out), 0);

    // R2: zero template, g=0 passes the state through.
    fill_random(-64, 63, 0, 0);
    run_frame(1'b0);

    // R2/R7: zero template with constants.
    fill_random(-30, 30, -30, 30);
    run_frame(1'b0);

    // R3: a single corner tap on a gradient exposes border replication.
    for (int n = 0; n < NPX; n++) begin fr_state[n] = (n / TW) * 7 + (n % TW) - 20; fr_const[n] = 0; end
    write_coef(8, 64);
    run_frame(1'b0);
    write_coef(8, 0);
    write_coef(0, -64);
    run_frame(1'b0);
    write_coef(0, 0);

    // R4: rounding toward zero for negative totals.
    for (int n = 0; n < NPX; n++) begin fr_state[n] = -1; fr_const[n] = 0; end
    write_coef(0, 1);
    run_frame(1'b0);

    // R4: clamp at both ends.
    begin
      int hi_c [9];
      for (int i = 0; i < 9; i++) hi_c[i] = 40;
      set_all_coefs(hi_c);
    end
    for (int n = 0; n < NPX; n++) begin fr_state[n] = 63; fr_const[n] = 100; end
    run_frame(1'b0);
    for (int n = 0; n < NPX; n++) begin fr_state[n] = -64; fr_const[n] = -100; end
    run_frame(1'b0);

    // R8: write mid-frame and write with selector beyond 8 are both ignored.
    set_all_coefs(cz);
    begin
      int rc [9];
      for (int i = 0; i < 9; i++) rc[i] = int'($urandom_range(64)) - 32;
      set_all_coefs(rc);
    end
    write_coef(12, 77);
    fill_random(-64, 63, -40, 40);
    run_frame(1'b1);
    fill_random(-64, 63, -40, 40);
    run_frame(1'b0);

    // R9 and R2: back-to-back random frames with fresh templates.
    for (int f = 0; f < 8; f++) begin
      if (f % 2 == 0) begin
        int rc [9];
        for (int i = 0; i < 9; i++) rc[i] = int'($urandom_range(128)) - 64;
        set_all_coefs(rc);
      end
      fill_random(-64, 63, -64, 63);
      run_frame(1'b0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R5 actual=%0d expected=%0d", out_idx, NPX);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule